// File: doc/BRIEF.md
# Sample FIFO with Interrupt Status

This block sits between an analog converter and a host processor. Each finished conversion arrives as a 12-bit result with a 4-bit channel tag. The block packs the two into one 16-bit word and stores it in a first-in, first-out queue. The host drains the queue by reading a data register on a small byte-addressed register bus.

A status register shows three things: a sticky bit saying a new sample has been stored, a sticky bit saying a sample was lost because the queue was full, and a start-source select bit. An interrupt control register holds an enable bit, a 3-bit line select and a 2-bit pacer select. The select fields go straight out to neighbouring logic. The single interrupt output is high only while the enable bit and the stored-sample bit are both set. Any write to a dedicated clear offset removes both sticky bits. A lost sample sets only its own status bit and never raises the interrupt by itself.

A write to the data offset sends a one-cycle request for a software-started conversion. The block performs that conversion itself only through its sample input.

Top module: `smpl_fifo_irq`

## Requirements
- R1: After reset the queue is empty, the status register (offset 2) and control register (offset 5) read 0x0000, `irq_out`, `sw_conv` and `ext_start` are low, and a data read returns 0x0000.
- R2: A stored sample reads back at offset 0 as {value[11:0], tag[3:0]}, with the value in bits 15:4 and the tag in bits 3:0. Words come out in arrival order, and each read of a non-empty queue removes one word.
- R3: The queue holds exactly DEPTH words (1024 by default). All DEPTH words read back intact.
- R4: A sample that arrives while the queue is full, with no pop in the same cycle, is discarded. It sets status bit 5, which stays set until a write to offset 4, and it does not set status bit 7.
- R5: Status bit 7 is set in the cycle after a sample is stored and is cleared by a write of any value to offset 4. If a store and a clear happen in the same cycle, bit 7 ends up set.
- R6: `irq_out` is high exactly when control bit 7 (enable) and status bit 7 are both set.
- R7: Offset 5 stores the pacer select in bits 1:0, the line select in bits 6:4 and the enable in bit 7, and drives them on `pacer_sel` and `irq_line`. Bits 3:2 always read as zero.
- R8: Status bit 0 is writable and drives `ext_start`. Writes to the other status bits have no effect.
- R9: A write to offset 0 makes `sw_conv` high for the one cycle after the write.
- R10: A read of an empty queue returns the last word removed (0x0000 if none yet) and changes neither the queue nor its order.
- R11: When the queue is full, a pop and an arriving sample in the same cycle both take effect, and no overrun is flagged.
- R12: Reads of offsets 1, 3, 6 and 7 return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A finished sample is present this cycle |
| smp_tag | input | 4 | Channel tag of the sample |
| smp_val | input | 12 | Conversion result |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the strobe |
| sw_conv | output | 1 | One-cycle software conversion request |
| ext_start | output | 1 | External start source selected |
| pacer_sel | output | 2 | Pacer source select |
| irq_line | output | 3 | Interrupt line select |
| irq_out | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check these properties: the fill level never passes the depth; a drop on a full queue leaves the level unchanged and sets the overrun bit; the overrun bit stays set until a clear; an empty read leaves the queue empty; the interrupt never fires without a pending sample; and a conversion request always follows a data-offset write. Only the bench scenarios can show the word packing and arrival order, the exact words that survive an overrun, the replayed last word, the simultaneous push and pop at full depth, the set-over-clear priority and the full sweep of control register values.

// File: rtl/sfq_pkg.sv
`timescale 1ns/1ps
package sfq_pkg;
    localparam int SMP_W  = 12;
    localparam int TAG_W  = 4;
    localparam int WORD_W = SMP_W + TAG_W;

    // register offsets decoded by the host software
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_CLR  = 3'd4;
    localparam logic [2:0] OFS_CTRL = 3'd5;

    typedef struct packed {
        logic pend;
        logic ovr;
        logic ext;
    } stat_t;

    typedef struct packed {
        logic       en;
        logic [2:0] line;
        logic [1:0] pacer;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] pack_word(input logic [TAG_W-1:0] tag,
                                                    input logic [SMP_W-1:0] val);
        return {val, tag};
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        logic [7:0] b;
        b    = '0;
        b[7] = s.pend;
        b[5] = s.ovr;
        b[0] = s.ext;
        return b;
    endfunction

    function automatic logic [7:0] ctrl_byte(input ctrl_t c);
        return {c.en, c.line, 2'b00, c.pacer};
    endfunction
endpackage

// File: rtl/sfq_store.sv
`timescale 1ns/1ps
module sfq_store #(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] head,
    output logic [CW-1:0]     fill,
    output logic              full,
    output logic              empty
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WORD_W-1:0] mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (push) ptr_d.wp = bump(ptr_q.wp);
        if (pop)  ptr_d.rp = bump(ptr_q.rp);
        case ({push, pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[ptr_q.wp] <= wdata;
    end

    assign head  = mem[ptr_q.rp];
    assign fill  = ptr_q.cnt;
    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign empty = (ptr_q.cnt == '0);
endmodule

// File: rtl/sfq_regs.sv
`timescale 1ns/1ps
module sfq_regs
    import sfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_data,
    input  logic       wr_stat,
    input  logic       wr_clr,
    input  logic       wr_ctrl,
    input  logic [7:0] wdata,
    input  logic       stored,
    input  logic       dropped,
    output stat_t      stat,
    output ctrl_t      ctrl,
    output logic       conv
);
    typedef struct packed {
        stat_t st;
        ctrl_t ct;
        logic  conv;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.conv = wr_data;
        if (wr_stat) r_d.st.ext = wdata[0];
        if (wr_ctrl) begin
            r_d.ct.en    = wdata[7];
            r_d.ct.line  = wdata[6:4];
            r_d.ct.pacer = wdata[1:0];
        end
        if (wr_clr) begin
            r_d.st.pend = 1'b0;
            r_d.st.ovr  = 1'b0;
        end
        // new events take priority over a clear in the same cycle
        if (stored)  r_d.st.pend = 1'b1;
        if (dropped) r_d.st.ovr  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign stat = r_q.st;
    assign ctrl = r_q.ct;
    assign conv = r_q.conv;
endmodule

// File: rtl/smpl_fifo_irq.sv
`timescale 1ns/1ps
module smpl_fifo_irq
    import sfq_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [TAG_W-1:0]  smp_tag,
    input  logic [SMP_W-1:0]  smp_val,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              sw_conv,
    output logic              ext_start,
    output logic [1:0]        pacer_sel,
    output logic [2:0]        irq_line,
    output logic              irq_out
);
    logic [WORD_W-1:0] head;
    logic [CW-1:0]     fill;
    logic              full, empty;
    logic              pop, stored, dropped;
    logic              pend_w, ovr_w;
    stat_t             stat;
    ctrl_t             ctrl;

    typedef struct packed {
        logic [WORD_W-1:0] last;
    } hold_t;

    hold_t h_d, h_q;

    assign pop     = bus_rd && (bus_addr == OFS_DATA) && !empty;
    assign stored  = smp_valid && (!full || pop);
    assign dropped = smp_valid && full && !pop;

    sfq_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (stored),
        .pop   (pop),
        .wdata (pack_word(smp_tag, smp_val)),
        .head  (head),
        .fill  (fill),
        .full  (full),
        .empty (empty)
    );

    sfq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (bus_wr && (bus_addr == OFS_DATA)),
        .wr_stat (bus_wr && (bus_addr == OFS_STAT)),
        .wr_clr  (bus_wr && (bus_addr == OFS_CLR)),
        .wr_ctrl (bus_wr && (bus_addr == OFS_CTRL)),
        .wdata   (bus_wdata),
        .stored  (stored),
        .dropped (dropped),
        .stat    (stat),
        .ctrl    (ctrl),
        .conv    (sw_conv)
    );

    always_comb begin
        h_d = h_q;
        if (pop) h_d.last = head;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = empty ? h_q.last : head;
            OFS_STAT: bus_rdata = {8'h00, stat_byte(stat)};
            OFS_CTRL: bus_rdata = {8'h00, ctrl_byte(ctrl)};
            default:  bus_rdata = '0;
        endcase
    end

    assign pend_w    = stat.pend;
    assign ovr_w     = stat.ovr;
    assign ext_start = stat.ext;
    assign pacer_sel = ctrl.pacer;
    assign irq_line  = ctrl.line;
    assign irq_out   = ctrl.en && pend_w;
endmodule

// File: rtl/sfq_chk.sv
`timescale 1ns/1ps
module sfq_chk #(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [2:0]    bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          sw_conv,
    input logic          irq_out,
    input logic [CW-1:0] fill,
    input logic          pend_w,
    input logic          ovr_w
);
    logic clr_wr, data_wr, data_rd, is_full, is_empty;
    assign clr_wr   = bus_wr && (bus_addr == 3'd4);
    assign data_wr  = bus_wr && (bus_addr == 3'd0);
    assign data_rd  = bus_rd && (bus_addr == 3'd0);
    assign is_full  = (fill == CW'(DEPTH));
    assign is_empty = (fill == '0);

    a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        is_full && smp_valid && !data_rd |=> ovr_w && $stable(fill));

    a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_w && !clr_wr |=> ovr_w);

    a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        is_empty && data_rd && !smp_valid |=> fill == '0);

    a_r6_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> pend_w);

    a_r9_conv_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> sw_conv);

    a_r5_clear_drops_pend: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !smp_valid |=> !pend_w);
endmodule

bind smpl_fifo_irq sfq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .sw_conv   (sw_conv),
    .irq_out   (irq_out),
    .fill      (fill),
    .pend_w    (pend_w),
    .ovr_w     (ovr_w)
);

// File: tb/sim_smpl_fifo_irq.sv
`timescale 1ns/1ps
module sim_smpl_fifo_irq;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        smp_valid;
    logic [3:0]  smp_tag;
    logic [11:0] smp_val;
    logic [2:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata;
    logic [15:0] bus_rdata;
    logic        sw_conv, ext_start, irq_out;
    logic [1:0]  pacer_sel;
    logic [2:0]  irq_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    smpl_fifo_irq #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_tag(smp_tag),
        .smp_val(smp_val), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_conv(sw_conv),
        .ext_start(ext_start), .pacer_sel(pacer_sel), .irq_line(irq_line),
        .irq_out(irq_out)
    );

    function automatic logic [11:0] val_of(input int i);
        return 12'((i * 273 + 5) % 4096);
    endfunction

    function automatic logic [15:0] word_of(input int i);
        return {val_of(i), 4'(i % 16)};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push(input int i);
        @(negedge clk);
        smp_valid = 1'b1; smp_tag = 4'(i % 16); smp_val = val_of(i);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        rst_n = 1'b0; smp_valid = 1'b0; smp_tag = '0; smp_val = '0;
        bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd2, d); chk(d, 16'h0000, "R1 status");
        bus_read(3'd5, d); chk(d, 16'h0000, "R1 control");
        chk({13'd0, irq_out, sw_conv, ext_start}, 16'h0000, "R1 outputs");
        bus_read(3'd0, d); chk(d, 16'h0000, "R1 R10 empty data read");

        // R12 unmapped offsets
        foreach (d[k]) if (k < 1) begin end
        for (int a = 1; a < 8; a += 2) begin
            if (a == 5) continue;
            bus_read(3'(a), d); chk(d, 16'h0000, "R12 unmapped");
        end
        bus_read(3'd6, d); chk(d, 16'h0000, "R12 offset 6");

        // R7 control register sweep
        for (int v = 0; v < 256; v++) begin
            bus_write(3'd5, 8'(v));
            bus_read(3'd5, d); chk(d, 16'(v & 8'hF3), "R7 readback");
            chk({11'd0, irq_line, pacer_sel}, 16'({v[6:4], v[1:0]}), "R7 outputs");
        end
        bus_write(3'd5, 8'h00);

        // R8 status write: only bit 0 sticks
        bus_write(3'd2, 8'hFF);
        bus_read(3'd2, d); chk(d, 16'h0001, "R8 status bit0 only");
        chk({15'd0, ext_start}, 16'd1, "R8 ext_start high");
        bus_write(3'd2, 8'hFE);
        bus_read(3'd2, d); chk(d, 16'h0000, "R8 status cleared");

        // R9 conversion request pulse
        bus_write(3'd0, 8'h5A);
        #1 chk({15'd0, sw_conv}, 16'd1, "R9 pulse");
        @(negedge clk); #1 chk({15'd0, sw_conv}, 16'd0, "R9 pulse ends");

        // R5 R6 pending and interrupt gating
        push(3);
        bus_read(3'd2, d); chk(d, 16'h0080, "R5 pending set");
        chk({15'd0, irq_out}, 16'd0, "R6 disabled");
        bus_write(3'd5, 8'h80);
        #1 chk({15'd0, irq_out}, 16'd1, "R6 enabled");
        bus_write(3'd4, 8'h00);
        bus_read(3'd2, d); chk(d, 16'h0000, "R5 cleared");
        chk({15'd0, irq_out}, 16'd0, "R6 low after clear");
        bus_read(3'd0, d); chk(d, word_of(3), "R2 single word");

        // R2 R3 fill to depth and drain in order
        for (int i = 0; i < DEPTH; i++) push(10 + i);
        bus_write(3'd4, 8'h00);
        // R4 drop on full, no interrupt from overrun
        push(99);
        bus_read(3'd2, d); chk(d, 16'h0020, "R4 overrun only");
        chk({15'd0, irq_out}, 16'd0, "R4 no irq");
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(3'd0, d); chk(d, word_of(10 + i), "R2 R3 order");
        end
        // R10 empty read repeats last word
        bus_read(3'd0, d); chk(d, word_of(10 + DEPTH - 1), "R10 repeat");
        bus_read(3'd0, d); chk(d, word_of(10 + DEPTH - 1), "R10 repeat again");
        bus_read(3'd2, d); chk(d, 16'h0020, "R4 sticky");
        push(40);
        bus_read(3'd0, d); chk(d, word_of(40), "R10 pointers kept");
        bus_write(3'd4, 8'h33);
        bus_read(3'd2, d); chk(d, 16'h0000, "R4 cleared");

        // R11 push and pop together when full
        for (int i = 0; i < DEPTH; i++) push(50 + i);
        bus_write(3'd4, 8'h00);
        @(negedge clk);
        bus_addr = 3'd0; bus_rd = 1'b1;
        smp_valid = 1'b1; smp_tag = 4'(77 % 16); smp_val = val_of(77);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; smp_valid = 1'b0;
        chk(d, word_of(50), "R11 popped head");
        bus_read(3'd2, d); chk(d, 16'h0080, "R11 no overrun");
        for (int i = 1; i < DEPTH; i++) begin
            bus_read(3'd0, d); chk(d, word_of(50 + i), "R11 order");
        end
        bus_read(3'd0, d); chk(d, word_of(77), "R11 new word kept");

        // R5 store wins over same-cycle clear
        bus_write(3'd4, 8'h00);
        @(negedge clk);
        bus_addr = 3'd4; bus_wr = 1'b1;
        smp_valid = 1'b1; smp_tag = 4'd1; smp_val = val_of(1);
        @(negedge clk);
        bus_wr = 1'b0; smp_valid = 1'b0;
        bus_read(3'd2, d); chk(d, 16'h0080, "R5 set wins");
        chk({15'd0, irq_out}, 16'd1, "R6 irq with enable");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule